// File: doc/BRIEF.md
# Memory Type Range Matcher

This block resolves the memory type of a physical address from a small bank of programmable variable-range entries. Each entry carries a base, a mask, a type code and an enable bit. A lookup address selects an entry when the address and the base agree on every bit the mask keeps. One entry can therefore cover only a power-of-two region whose base is aligned to its size. For such a region of size S, the mask keeps every bit at position log2(S) and above.

Several entries may cover the same address. Their types are then combined by type precedence, and the entry index plays no part. An uncachable entry overrides everything else. Write-through beats write-back. Entries of one type agree. Any other mix is flagged as undefined and reported as uncachable. When no enabled entry covers the address, a programmable fallback type is reported. These rules let software over-cover a region with one large entry and carve out the excess with an uncachable entry.

The lookup result is registered, so it appears one cycle after the request. A single write port programs the entry fields and the fallback type.

Top module: `mtr_matcher`

## Requirements
- R1: An enabled entry hits when (lkAddr AND mask) equals (base AND mask). An address one past the top of an aligned region does not hit that entry.
- R2: After reset all entries are disabled and the fallback type is UC (0). A disabled entry never hits, whatever its base and mask hold.
- R3: When no enabled entry hits, outHit is 0, outUndef is 0 and outType equals the fallback type.
- R4: If any hitting entry has type UC (0), outType is UC and outUndef is 0.
- R5: If the hitting entries hold only WT (4) and WB (6) codes, with both present, outType is WT.
- R6: If every hitting entry holds the same legal code (UC=0, WC=1, WT=4, WP=5, WB=6), outType is that code and outUndef is 0.
- R7: Any other combination of hits sets outUndef to 1 and outType to UC. This includes WC with WT, and any hit on a reserved code (2, 3, 7).
- R8: The lookup has a latency of one cycle. outValid is high exactly in the cycle after lkValid was sampled high. Back-to-back lookups return results in order, one per cycle.
- R9: A write updates the entry at the clock edge. A lookup sampled at that same edge sees the old contents. Any later lookup sees the new contents.
- R10: Write field select wrField works as follows:
  - 0 writes the base of entry wrIdx.
  - 1 writes its mask.
  - 2 writes its attributes: type = wrData[2:0], enable = wrData[31].
  - 3 writes the fallback type from wrData[2:0], and wrIdx is ignored.
- R11: A 64 KiB WT entry with an 8 KiB UC entry at its top 8 KiB gives UC over those 8 KiB and WT over the remaining 56 KiB.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for the programming port |
| wrField | input | 2 | Field select: 0 base, 1 mask, 2 attributes, 3 fallback type |
| wrIdx | input | 3 | Entry index for field writes |
| wrData | input | 32 | Write data |
| lkValid | input | 1 | Lookup request |
| lkAddr | input | 32 | Lookup address |
| outValid | output | 1 | Result valid, one cycle after lkValid |
| outType | output | 3 | Resolved memory type code |
| outUndef | output | 1 | Overlap combination was undefined |
| outHit | output | 1 | At least one enabled entry hit |

## Verification
The bench probes the edges of aligned regions: the last byte inside a region and the first byte past it. A matcher that compared bounds wrongly, or dropped a mask bit, would misreport at those edges.

It builds overlaps of every kind:
- an uncachable carve-out inside a larger write-through entry
- write-through with write-back
- two entries of the same type
- write-combining with write-through
- a reserved code

Each of these would show a wrong type, or a missing or spurious undefined flag, if precedence were taken from the entry index.

It also issues a write and a lookup in the same cycle. A design that forwarded the new contents would return the updated type one lookup too early.

Finally, it checks three more cases:
- a disabled entry that covers the address, which must not hit
- back-to-back lookups, which catch an extra pipeline stage
- a fallback-type write, whose effect is seen through a miss

// File: rtl/mtr_pkg.sv
package mtr_pkg;

  localparam int ADDR_W  = 32;
  localparam int NUM_ENT = 8;
  localparam int TYPE_W  = 3;
  localparam int CODES   = 1 << TYPE_W;

  localparam logic [TYPE_W-1:0] MT_UC = 3'd0;
  localparam logic [TYPE_W-1:0] MT_WC = 3'd1;
  localparam logic [TYPE_W-1:0] MT_WT = 3'd4;
  localparam logic [TYPE_W-1:0] MT_WP = 3'd5;
  localparam logic [TYPE_W-1:0] MT_WB = 3'd6;

  // codes that are allowed to stand alone
  localparam logic [CODES-1:0] LEGAL_SET =
    (CODES'(1) << MT_UC) | (CODES'(1) << MT_WC) | (CODES'(1) << MT_WT) |
    (CODES'(1) << MT_WP) | (CODES'(1) << MT_WB);

  // the one mixed set with a defined outcome
  localparam logic [CODES-1:0] WT_WB_SET = (CODES'(1) << MT_WT) | (CODES'(1) << MT_WB);

  typedef enum logic [1:0] {
    FLD_BASE = 2'd0,
    FLD_MASK = 2'd1,
    FLD_ATTR = 2'd2,
    FLD_DFLT = 2'd3
  } fld_e;

  typedef struct packed {
    logic baseWr;
    logic maskWr;
    logic attrWr;
    logic dfltWr;
  } wrStrobe_t;

endpackage

// File: rtl/mtr_ctrl.sv
module mtr_ctrl
  import mtr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [1:0] wrField,
  input  logic       lkValid,
  output wrStrobe_t  strb,
  output logic       lkCapture,
  output logic       outValid
);

  always_comb begin
    strb        = '0;
    strb.baseWr = wrEn && (wrField == FLD_BASE);
    strb.maskWr = wrEn && (wrField == FLD_MASK);
    strb.attrWr = wrEn && (wrField == FLD_ATTR);
    strb.dfltWr = wrEn && (wrField == FLD_DFLT);
  end

  assign lkCapture = lkValid;

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= lkValid;
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.baseWr, strb.maskWr, strb.attrWr, strb.dfltWr})); // R10

  AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    lkValid |=> outValid); // R8

  AST_NO_SPURIOUS_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    !lkValid |=> !outValid); // R8

endmodule

// File: rtl/mtr_resolve.sv
module mtr_resolve
  import mtr_pkg::*;
#(
  parameter int TypeW = TYPE_W,
  localparam int Codes = 1 << TypeW
) (
  input  logic [Codes-1:0] typeSet,
  input  logic [TypeW-1:0] dfltType,
  output logic [TypeW-1:0] resType,
  output logic             resUndef,
  output logic             resHit
);

  logic [TypeW-1:0] soleCode;
  logic             single;
  logic             allLegal;

  always_comb begin
    soleCode = '0;
    for (int c = 0; c < Codes; c++) begin
      if (typeSet[c]) soleCode = c[TypeW-1:0];
    end
  end

  assign single   = ($countones(typeSet) == 1);
  assign allLegal = ((typeSet & ~LEGAL_SET) == '0);
  assign resHit   = |typeSet;

  always_comb begin
    resType  = MT_UC;
    resUndef = 1'b0;
    if (!resHit) begin
      resType = dfltType;
    end else if (typeSet[MT_UC]) begin
      resType = MT_UC;
    end else if (single && allLegal) begin
      resType = soleCode;
    end else if (typeSet == WT_WB_SET) begin
      resType = MT_WT;
    end else begin
      resType  = MT_UC;
      resUndef = 1'b1;
    end
  end

endmodule

// File: rtl/mtr_datapath.sv
module mtr_datapath
  import mtr_pkg::*;
#(
  parameter int AddrW  = ADDR_W,
  parameter int NumEnt = NUM_ENT,
  parameter int TypeW  = TYPE_W,
  localparam int IdxW  = (NumEnt > 1) ? $clog2(NumEnt) : 1,
  localparam int Codes = 1 << TypeW
) (
  input  logic             clk,
  input  logic             rstN,
  input  wrStrobe_t        strb,
  input  logic [IdxW-1:0]  wrIdx,
  input  logic [AddrW-1:0] wrData,
  input  logic [AddrW-1:0] lkAddr,
  input  logic             lkCapture,
  output logic [TypeW-1:0] outType,
  output logic             outUndef,
  output logic             outHit
);

  logic [AddrW-1:0] baseQ [NumEnt];
  logic [AddrW-1:0] maskQ [NumEnt];
  logic [TypeW-1:0] typeQ [NumEnt];
  logic [NumEnt-1:0] enQ;
  logic [NumEnt-1:0] hitVec;
  logic [NumEnt-1:0] ucEnt;
  logic [TypeW-1:0] dfltQ;
  logic [Codes-1:0] typeSet;
  logic [TypeW-1:0] resType;
  logic             resUndef;
  logic             resHit;

  for (genvar i = 0; i < NumEnt; i++) begin : gEnt
    logic sel;
    assign sel = (wrIdx == IdxW'(i));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        baseQ[i] <= '0;
        maskQ[i] <= '0;
        typeQ[i] <= MT_UC;
        enQ[i]   <= 1'b0;
      end else begin
        if (strb.baseWr && sel) baseQ[i] <= wrData;
        if (strb.maskWr && sel) maskQ[i] <= wrData;
        if (strb.attrWr && sel) begin
          typeQ[i] <= wrData[TypeW-1:0];
          enQ[i]   <= wrData[AddrW-1];
        end
      end
    end

    assign hitVec[i] = enQ[i] && ((lkAddr & maskQ[i]) == (baseQ[i] & maskQ[i]));
    assign ucEnt[i]  = enQ[i] && (typeQ[i] == MT_UC);
  end

  always_ff @(posedge clk) begin
    if (!rstN)            dfltQ <= MT_UC;
    else if (strb.dfltWr) dfltQ <= wrData[TypeW-1:0];
  end

  always_comb begin
    typeSet = '0;
    for (int i = 0; i < NumEnt; i++) begin
      if (hitVec[i]) typeSet[typeQ[i]] = 1'b1;
    end
  end

  mtr_resolve #(.TypeW(TypeW)) uResolve (
    .typeSet (typeSet),
    .dfltType(dfltQ),
    .resType (resType),
    .resUndef(resUndef),
    .resHit  (resHit)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outType  <= MT_UC;
      outUndef <= 1'b0;
      outHit   <= 1'b0;
    end else if (lkCapture) begin
      outType  <= resType;
      outUndef <= resUndef;
      outHit   <= resHit;
    end
  end

  AST_UC_ENTRY_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (lkCapture && |(hitVec & ucEnt)) |=> (outType == MT_UC && !outUndef)); // R4

  AST_MISS_GIVES_FALLBACK: assert property (@(posedge clk) disable iff (!rstN)
    (lkCapture && hitVec == '0) |=> (outType == $past(dfltQ) && !outHit && !outUndef)); // R3

  AST_UNDEF_REPORTS_UC: assert property (@(posedge clk) disable iff (!rstN)
    outUndef |-> (outType == MT_UC && outHit)); // R7

  AST_DISABLED_NO_HIT: assert property (@(posedge clk) disable iff (!rstN)
    (lkCapture && enQ == '0) |=> !outHit); // R2

endmodule

// File: rtl/mtr_matcher.sv
module mtr_matcher
  import mtr_pkg::*;
#(
  parameter int AddrW  = ADDR_W,
  parameter int NumEnt = NUM_ENT,
  parameter int TypeW  = TYPE_W,
  localparam int IdxW  = (NumEnt > 1) ? $clog2(NumEnt) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrField,
  input  logic [IdxW-1:0]  wrIdx,
  input  logic [AddrW-1:0] wrData,
  input  logic             lkValid,
  input  logic [AddrW-1:0] lkAddr,
  output logic             outValid,
  output logic [TypeW-1:0] outType,
  output logic             outUndef,
  output logic             outHit
);

  wrStrobe_t strb;
  logic      lkCapture;

  mtr_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrField  (wrField),
    .lkValid  (lkValid),
    .strb     (strb),
    .lkCapture(lkCapture),
    .outValid (outValid)
  );

  mtr_datapath #(.AddrW(AddrW), .NumEnt(NumEnt), .TypeW(TypeW)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wrIdx    (wrIdx),
    .wrData   (wrData),
    .lkAddr   (lkAddr),
    .lkCapture(lkCapture),
    .outType  (outType),
    .outUndef (outUndef),
    .outHit   (outHit)
  );

endmodule

// File: tb/tb_mtr_matcher.sv
`timescale 1ns/100ps
module tb_mtr_matcher;

  localparam logic [2:0] UC = 3'd0, WC = 3'd1, WT = 3'd4, WP = 3'd5, WB = 3'd6;
  localparam logic [31:0] EN = 32'h8000_0000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrField = '0;
  logic [2:0]  wrIdx = '0;
  logic [31:0] wrData = '0;
  logic        lkValid = 1'b0;
  logic [31:0] lkAddr = '0;
  logic        outValid;
  logic [2:0]  outType;
  logic        outUndef;
  logic        outHit;

  int checks = 0;
  int errors = 0;
  bit monOn = 0;
  bit lkPrev = 0;

  typedef struct {
    logic [31:0] a;
    logic [2:0]  t;
    logic        u;
    logic        h;
    string       req;
  } exp_t;

  exp_t expQ[$];

  always #2.5 clk = ~clk;

  mtr_matcher dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrField(wrField), .wrIdx(wrIdx),
    .wrData(wrData), .lkValid(lkValid), .lkAddr(lkAddr), .outValid(outValid),
    .outType(outType), .outUndef(outUndef), .outHit(outHit)
  );

  // monitor: compares results as they leave the design
  always @(negedge clk) begin
    if (monOn) begin
      checks++;
      if (outValid !== lkPrev) begin
        errors++;
        $display("FAIL R8 outValid got %0b exp %0b", outValid, lkPrev);
      end
      if (outValid === 1'b1) begin
        if (expQ.size() == 0) begin
          errors++;
          $display("FAIL R8 unexpected result got 1 exp 0");
        end else begin
          exp_t e;
          e = expQ.pop_front();
          checks++;
          if (outType !== e.t || outUndef !== e.u || outHit !== e.h) begin
            errors++;
            $display("FAIL %s addr=%h got type=%0d undef=%0b hit=%0b exp type=%0d undef=%0b hit=%0b",
                     e.req, e.a, outType, outUndef, outHit, e.t, e.u, e.h);
          end
        end
      end
    end
    lkPrev = lkValid;
  end

  task automatic wr(input logic [1:0] f, input int idx, input logic [31:0] d);
    @(posedge clk); #1;
    wrEn = 1'b1; wrField = f; wrIdx = idx[2:0]; wrData = d;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic setEnt(input int idx, input logic [31:0] b, input logic [31:0] m,
                        input logic [2:0] t, input bit en);
    wr(2'd0, idx, b);
    wr(2'd1, idx, m);
    wr(2'd2, idx, (en ? EN : 32'h0) | {29'h0, t});
  endtask

  // drives one lookup for one cycle; leaves lkValid high if chained
  task automatic look(input logic [31:0] a, input logic [2:0] t, input logic u,
                      input logic h, input string req, input bit keep = 0);
    exp_t e;
    @(posedge clk); #1;
    lkValid = 1'b1; lkAddr = a;
    e.a = a; e.t = t; e.u = u; e.h = h; e.req = req;
    expQ.push_back(e);
    if (!keep) begin
      @(posedge clk); #1;
      lkValid = 1'b0;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog expired got hang exp completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    checks++;
    if (outValid !== 1'b0 || outHit !== 1'b0 || outType !== UC) begin
      errors++;
      $display("FAIL R2 reset outputs got v=%0b h=%0b t=%0d exp 0 0 0", outValid, outHit, outType);
    end
    monOn = 1;

    // R2/R3: empty table falls back to UC
    look(32'h0000_1000, UC, 0, 0, "R2 empty table");
    // R10 field 3 ignores index; R3 fallback seen through a miss
    wr(2'd3, 5, {29'h0, WB});
    look(32'h0000_1000, WB, 0, 0, "R3 fallback WB");

    // R2: disabled entry covering the address does not hit
    setEnt(0, 32'hA864_2000, 32'hFFFF_E000, WT, 0);
    look(32'hA864_2000, WB, 0, 0, "R2 disabled entry");
    wr(2'd2, 0, EN | {29'h0, WT});
    look(32'hA864_2000, WT, 0, 1, "R1 base hit");
    look(32'hA864_3FFF, WT, 0, 1, "R1 top byte");
    look(32'hA864_4000, WB, 0, 0, "R1 one past top");

    setEnt(1, 32'hA864_4000, 32'hFFFF_C000, WB, 1);
    setEnt(2, 32'hA864_8000, 32'hFFFF_8000, WP, 1);
    look(32'hA864_7FFC, WB, 0, 1, "R1 16K entry");
    look(32'hA864_FFFF, WP, 0, 1, "R6 single WP");
    look(32'hA865_0000, WB, 0, 0, "R3 above regions");

    // R11 over-cover with carve-out, R4 UC wins
    setEnt(3, 32'hE000_0000, 32'hFFFF_0000, WT, 1);
    setEnt(4, 32'hE000_E000, 32'hFFFF_E000, UC, 1);
    look(32'hE000_0000, WT, 0, 1, "R11 low part WT");
    look(32'hE000_DFFF, WT, 0, 1, "R11 below carve WT");
    look(32'hE000_E000, UC, 0, 1, "R4 carve start UC");
    look(32'hE000_FFFF, UC, 0, 1, "R11 carve end UC");
    look(32'hE001_0000, WB, 0, 0, "R3 past 64K");

    // R5 WT with WB
    setEnt(5, 32'hE000_0000, 32'hFFFF_8000, WB, 1);
    look(32'hE000_1000, WT, 0, 1, "R5 WT over WB");

    // R6 two entries same type
    setEnt(6, 32'h1000_0000, 32'hFFFF_F000, WT, 1);
    setEnt(7, 32'h1000_0000, 32'hFFFF_0000, WT, 1);
    look(32'h1000_0010, WT, 0, 1, "R6 WT and WT");

    // R7 WC with WT is undefined
    wr(2'd2, 7, EN | {29'h0, WC});
    look(32'h1000_0010, UC, 1, 1, "R7 WC with WT");
    look(32'h1000_8000, WC, 0, 1, "R6 single WC");
    wr(2'd2, 7, EN | 32'd3);
    look(32'h1000_8000, UC, 1, 1, "R7 reserved code");

    // R9 write and lookup at the same edge: old contents
    @(posedge clk); #1;
    wrEn = 1'b1; wrField = 2'd2; wrIdx = 3'd7; wrData = EN | {29'h0, WB};
    lkValid = 1'b1; lkAddr = 32'h1000_8000;
    begin
      exp_t e;
      e.a = 32'h1000_8000; e.t = UC; e.u = 1; e.h = 1; e.req = "R9 same-edge old";
      expQ.push_back(e);
    end
    @(posedge clk); #1;
    wrEn = 1'b0; lkValid = 1'b0;
    look(32'h1000_8000, WB, 0, 1, "R9 next lookup new");

    // R8 back-to-back lookups in order
    look(32'hE000_E004, UC, 0, 1, "R8 burst 1", 1);
    look(32'hA864_2004, WT, 0, 1, "R8 burst 2", 1);
    look(32'h0000_0000, WB, 0, 0, "R8 burst 3", 0);

    repeat (4) @(posedge clk);
    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL R8 missing results got %0d pending exp 0", expQ.size());
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule